// File: doc/BRIEF.md
# Stream Feature Record Collector

This block is the input stage of a four-stage inference pipeline (input, first layer, second layer, output). It receives feature words on an AXI4-Stream slave port, one feature per beat, and gathers eleven of them into one record. When the eleventh feature is accepted, the whole record is presented in parallel to the neuron datapath, together with a valid pulse one cycle long. Another record may begin on the very next beat.

Records are admitted against the space left in the downstream result buffer. That buffer reports how many free result slots it has. The collector keeps count of the records it has issued whose results have not yet landed. It lets a new record begin only if the free slots exceed that in-flight count. A simple write port holds two settings. One is a soft-reset bit that clears the pipeline state. The other is a batch length: the block raises a flag when the last record of a batch goes out. A stream packet that ends before the record is full throws away the partial record and sets a sticky error flag.

Top module: `rec_gather`

## Requirements
- R1: After rst_n is released, rec_valid, batch_done, err_flag and pipe_clear are 0, and s_tready is 1 whenever space_free is non-zero.
- R2: Each accepted beat carries one feature in s_tdata[15:0]. Bits 31:16 are ignored. The k-th accepted feature of a record (k = 0 to 10) appears on rec_feat[16k+15:16k].
- R3: rec_valid is high for exactly one cycle, in the cycle after the eleventh feature is accepted. The first beat of the next record may be accepted in that same cycle, so back-to-back records issue 11 cycles apart.
- R4: An s_tlast on a beat before the eleventh throws away the partial record, so no rec_valid follows. It also sets err_flag, which stays set until soft reset or rst_n. The next beat starts a new record at feature 0.
- R5: An s_tlast on the eleventh beat completes the record normally and leaves err_flag unchanged.
- R6: The first beat of a record is accepted only while space_free is greater than the in-flight count. The in-flight count rises by one when a record's eleventh beat is accepted and falls by one on each res_done pulse. s_tready is not gated by space during beats 1 to 10 of a record.
- R7: A write to address 1 sets the batch length from cfg_wdata[15:0]. batch_done goes to 1 together with the rec_valid of the last record of each batch. It stays 1 until the next rec_valid, and then the record count starts over. A batch length of 0 never raises batch_done.
- R8: A write to address 0 with cfg_wdata[0]=1 raises pipe_clear for one cycle in the next cycle, with s_tready 0 in that cycle. It clears the partial record, the in-flight count, the record count, batch_done and err_flag. The batch length is kept.
- R9: Writes to addresses 2 or 3, and writes to address 0 with cfg_wdata[0]=0, change neither the batch length nor pipe_clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 2 | Setting address: 0 control, 1 batch length |
| cfg_wdata | input | 32 | Setting write data |
| s_tdata | input | 32 | Stream data, feature in the low 16 bits |
| s_tvalid | input | 1 | Stream valid |
| s_tready | output | 1 | Stream ready |
| s_tlast | input | 1 | Stream end of packet |
| space_free | input | 16 | Free result slots in the downstream buffer |
| res_done | input | 1 | Pulse: one in-flight result reached the buffer |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_feat | output | 176 | Eleven 16-bit features of the record |
| batch_done | output | 1 | Last record of a batch issued |
| err_flag | output | 1 | Sticky short-packet error |
| pipe_clear | output | 1 | One-cycle clear pulse for the pipeline |

## Verification
Records are built from different seeds, and the upper data bits carry junk. This separates correct feature placement from shifted or mixed-up lanes and from leakage of the upper bits. Packets end at the eleventh beat, early, or not at all, which separates normal completion from the discard path. Two records sent back to back show whether a new record can start in the strobe cycle. The in-flight count is driven above and below the free space, and the space is removed in the middle of a record. Together these show that admission is checked only at the start of a record. Batch tests with lengths 2 and 0, run after writes to unused addresses, show whether the address decoding is exact.

// File: rtl/rg_pkg.sv
package rg_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_LEN  = 2'd1
    } reg_addr_e;
    localparam int CTRL_CLR_BIT = 0;
endpackage

// File: rtl/rg_cfg.sv
module rg_cfg #(
    parameter int CNT_W   = 16,
    parameter int WD_W    = 32,
    parameter int DEF_LEN = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [WD_W-1:0]  cfg_wdata,
    output logic             clr,
    output logic [CNT_W-1:0] batch_len
);
    import rg_pkg::*;

    typedef struct packed {
        logic             clr;
        logic [CNT_W-1:0] len;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_hi;

    assign unused_hi = ^cfg_wdata[WD_W-1:CNT_W];

    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.clr = cfg_we && (cfg_addr == REG_CTRL) && cfg_wdata[CTRL_CLR_BIT];
        if (cfg_we && (cfg_addr == REG_LEN))
            cfg_d.len = cfg_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.clr <= 1'b0;
            cfg_q.len <= CNT_W'(DEF_LEN);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign clr       = cfg_q.clr;
    assign batch_len = cfg_q.len;

    // R9
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we || cfg_addr != REG_LEN) |=> $stable(batch_len));
endmodule

// File: rtl/rg_collect.sv
module rg_collect #(
    parameter int NFEAT  = 11,
    parameter int FEAT_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    admit,
    input  logic [DATA_W-1:0]       s_tdata,
    input  logic                    s_tvalid,
    input  logic                    s_tlast,
    output logic                    s_tready,
    output logic                    commit,
    output logic                    rec_valid,
    output logic [NFEAT*FEAT_W-1:0] rec_feat,
    output logic                    err_flag
);
    localparam int IDX_W = $clog2(NFEAT);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NFEAT - 1);

    typedef struct packed {
        logic [IDX_W-1:0]             idx;
        logic [NFEAT-1:0][FEAT_W-1:0] feat;
        logic                         valid;
        logic                         err;
    } col_t;

    col_t col_d, col_q;
    logic acc, last_beat, unused_hi;

    assign unused_hi = ^s_tdata[DATA_W-1:FEAT_W];
    assign s_tready  = !clr && ((col_q.idx != '0) || admit);
    assign acc       = s_tvalid && s_tready;
    assign last_beat = (col_q.idx == LAST_IDX);
    assign commit    = acc && last_beat;

    always_comb begin
        col_d       = col_q;
        col_d.valid = 1'b0;
        if (clr) begin
            col_d = '0;
        end else if (acc) begin
            col_d.feat[col_q.idx] = s_tdata[FEAT_W-1:0];
            if (last_beat) begin
                col_d.idx   = '0;
                col_d.valid = 1'b1;
            end else if (s_tlast) begin
                col_d.idx = '0;
                col_d.err = 1'b1;
            end else begin
                col_d.idx = col_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    assign rec_valid = col_q.valid;
    assign rec_feat  = col_q.feat;
    assign err_flag  = col_q.err;

    // R3
    valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid);
    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr) |=> err_flag);
    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!rec_valid && !err_flag && col_q.idx == '0));
    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_q.idx <= LAST_IDX);
endmodule

// File: rtl/rg_track.sv
module rg_track #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             commit,
    input  logic             res_done,
    input  logic [CNT_W-1:0] space_free,
    input  logic [CNT_W-1:0] batch_len,
    output logic             admit,
    output logic             batch_done
);
    typedef struct packed {
        logic [CNT_W-1:0] infl;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [CNT_W:0] cnt_next;

    assign cnt_next = {1'b0, trk_q.cnt} + 1'b1;
    assign admit    = space_free > trk_q.infl;

    always_comb begin
        trk_d = trk_q;
        if (clr) begin
            trk_d = '0;
        end else begin
            if (commit && !res_done)
                trk_d.infl = trk_q.infl + 1'b1;
            else if (!commit && res_done && trk_q.infl != '0)
                trk_d.infl = trk_q.infl - 1'b1;
            if (commit) begin
                if (batch_len != '0 && cnt_next >= {1'b0, batch_len}) begin
                    trk_d.cnt  = '0;
                    trk_d.done = 1'b1;
                end else begin
                    trk_d.cnt  = cnt_next[CNT_W-1:0];
                    trk_d.done = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign batch_done = trk_q.done;

    // R7
    done_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batch_done) |-> $past(commit));
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !res_done && !clr) |-> (trk_q.infl != '1));
    // R8
    clear_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (trk_q.infl == '0 && !batch_done));
endmodule

// File: rtl/rec_gather.sv
module rec_gather #(
    parameter int NFEAT   = 11,
    parameter int FEAT_W  = 16,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int DEF_LEN = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_addr,
    input  logic [DATA_W-1:0]       cfg_wdata,
    input  logic [DATA_W-1:0]       s_tdata,
    input  logic                    s_tvalid,
    output logic                    s_tready,
    input  logic                    s_tlast,
    input  logic [CNT_W-1:0]        space_free,
    input  logic                    res_done,
    output logic                    rec_valid,
    output logic [NFEAT*FEAT_W-1:0] rec_feat,
    output logic                    batch_done,
    output logic                    err_flag,
    output logic                    pipe_clear
);
    logic             clr, admit, commit;
    logic [CNT_W-1:0] batch_len;

    rg_cfg #(.CNT_W(CNT_W), .WD_W(DATA_W), .DEF_LEN(DEF_LEN)) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .clr(clr), .batch_len(batch_len)
    );

    rg_collect #(.NFEAT(NFEAT), .FEAT_W(FEAT_W), .DATA_W(DATA_W)) col_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .admit(admit),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
        .s_tready(s_tready), .commit(commit), .rec_valid(rec_valid),
        .rec_feat(rec_feat), .err_flag(err_flag)
    );

    rg_track #(.CNT_W(CNT_W)) trk_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .commit(commit),
        .res_done(res_done), .space_free(space_free), .batch_len(batch_len),
        .admit(admit), .batch_done(batch_done)
    );

    assign pipe_clear = clr;
endmodule

// File: tb/rec_gather_tb_top.sv
module rec_gather_tb_top;
    localparam int CLK_P = 10;
    localparam int NF    = 11;
    localparam int NV    = 4;
    localparam int T_SEED [NV] = '{3, 17, 250, 41};
    localparam bit T_LAST [NV] = '{1'b1, 1'b0, 1'b1, 1'b0};
    localparam bit T_ERR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0};

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0;
    logic [1:0] cfg_addr = 0;
    logic [31:0] cfg_wdata = 0, s_tdata = 0;
    logic s_tvalid = 0, s_tlast = 0, res_done = 0;
    logic [15:0] space_free = 16'd100;
    logic s_tready, rec_valid, batch_done, err_flag, pipe_clear;
    logic [NF*16-1:0] rec_feat, last_feat;
    int checks = 0, errors = 0, vcount = 0, cyc = 0, vcyc = 0, c0;

    rec_gather dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .s_tlast(s_tlast), .space_free(space_free),
        .res_done(res_done), .rec_valid(rec_valid), .rec_feat(rec_feat),
        .batch_done(batch_done), .err_flag(err_flag), .pipe_clear(pipe_clear)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (rec_valid) begin
        vcount = vcount + 1; last_feat = rec_feat; vcyc = cyc;
    end

    function automatic logic [15:0] fval(int s, int k);
        return 16'((s * 4099 + k * 7919) ^ (s << 11));
    endfunction

    function automatic logic [NF*16-1:0] frec(int s);
        logic [NF*16-1:0] r;
        for (int k = 0; k < NF; k++) r[16*k +: 16] = fval(s, k);
        return r;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic beat(int s, int k, bit last);
        @(negedge clk);
        s_tvalid = 1; s_tlast = last;
        s_tdata = {16'hA5A5 ^ 16'(s * 31 + k), fval(s, k)};
        #1;
        while (!s_tready) begin @(negedge clk); #1; end
        @(posedge clk);
    endtask

    task automatic send_rec(int s, bit last_end);
        for (int k = 0; k < NF; k++) beat(s, k, last_end && k == NF - 1);
    endtask

    task automatic idle();
        @(negedge clk); s_tvalid = 0; s_tlast = 0; #1;
    endtask

    task automatic cfg_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk); cfg_we = 0; #1;
    endtask

    task automatic pulse_done();
        @(negedge clk); res_done = 1;
        @(posedge clk);
        @(negedge clk); res_done = 0; #1;
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; #1;
        // R1 reset state
        chk(!rec_valid && !batch_done && !err_flag && !pipe_clear, "R1 outputs low",
            {rec_valid, batch_done, err_flag, pipe_clear}, 0);
        chk(s_tready, "R1 ready", s_tready, 1);

        // R2 R5 table walk
        for (int i = 0; i < NV; i++) begin
            c0 = vcount;
            send_rec(T_SEED[i], T_LAST[i]);
            idle();
            chk(rec_valid, "R3 valid after 11th beat", rec_valid, 1);
            chk(rec_feat == frec(T_SEED[i]), "R2 feature lanes", rec_feat[63:0], frec(T_SEED[i]) & 64'hFFFFFFFFFFFFFFFF);
            chk(err_flag == T_ERR[i], "R5 err unchanged", err_flag, T_ERR[i]);
            @(negedge clk); #1;
            chk(!rec_valid && vcount == c0 + 1, "R3 single pulse", vcount - c0, 1);
        end

        // R3 back to back
        c0 = vcount;
        send_rec(60, 0);
        send_rec(61, 1);
        idle();
        chk(vcount == c0 + 2, "R3 two records", vcount - c0, 2);
        chk(last_feat == frec(61), "R3 second record lanes", last_feat[63:0], frec(61) & 64'hFFFFFFFFFFFFFFFF);
        chk(vcyc - c0 >= 0 && rec_valid, "R3 valid at end", rec_valid, 1);

        // R4 early tlast
        c0 = vcount;
        for (int k = 0; k < 4; k++) beat(70, k, k == 3);
        idle();
        repeat (2) @(negedge clk); #1;
        chk(err_flag, "R4 err set", err_flag, 1);
        chk(vcount == c0, "R4 no valid", vcount - c0, 0);
        send_rec(71, 0);
        idle();
        chk(rec_valid && rec_feat == frec(71), "R4 fresh record", rec_feat[63:0], frec(71) & 64'hFFFFFFFFFFFFFFFF);
        chk(err_flag, "R4 err sticky", err_flag, 1);

        // R6 admission with 7 in flight
        space_free = 16'd5; #1;
        chk(!s_tready, "R6 blocked 5<=7", s_tready, 0);
        space_free = 16'd8; #1;
        chk(s_tready, "R6 admitted 8>7", s_tready, 1);

        // R8 soft reset drops partial record
        for (int k = 0; k < 3; k++) beat(75, k, 0);
        idle();
        space_free = 16'd5;
        cfg_write(2'd0, 32'h1);
        chk(pipe_clear && !s_tready, "R8 clear cycle", {pipe_clear, s_tready}, 2'b10);
        @(negedge clk); #1;
        chk(!pipe_clear && !err_flag && s_tready, "R8 cleared state", {pipe_clear, err_flag, s_tready}, 3'b001);
        c0 = vcount;
        send_rec(80, 0);
        idle();
        chk(vcount == c0 + 1 && rec_feat == frec(80), "R8 partial dropped", rec_feat[63:0], frec(80) & 64'hFFFFFFFFFFFFFFFF);

        // R6 one in flight, one slot
        space_free = 16'd1;
        @(negedge clk); s_tvalid = 1; s_tdata = {16'h0, fval(90, 0)}; #1;
        chk(!s_tready, "R6 blocked 1<=1", s_tready, 0);
        s_tvalid = 0;
        pulse_done();
        chk(s_tready, "R6 res_done frees slot", s_tready, 1);
        beat(90, 0, 0);
        @(negedge clk); space_free = 16'd0; s_tvalid = 1; s_tdata = {16'h0, fval(90, 1)}; #1;
        chk(s_tready, "R6 mid record not gated", s_tready, 1);
        @(posedge clk);
        for (int k = 2; k < NF; k++) beat(90, k, 0);
        idle();
        chk(rec_valid && rec_feat == frec(90), "R6 record completes", rec_feat[63:0], frec(90) & 64'hFFFFFFFFFFFFFFFF);
        space_free = 16'd100;

        // R9 R7 decoding and batch of 2
        cfg_write(2'd0, 32'h1);
        cfg_write(2'd1, 32'h2);
        chk(!pipe_clear, "R9 len write no clear", pipe_clear, 0);
        cfg_write(2'd2, 32'h1);
        chk(!pipe_clear, "R9 addr2 ignored", pipe_clear, 0);
        cfg_write(2'd0, 32'h2);
        chk(!pipe_clear, "R9 bit0 clear ignored", pipe_clear, 0);
        cfg_write(2'd3, 32'h1);
        send_rec(100, 0); idle();
        chk(!batch_done, "R7 R9 not done after 1 of 2", batch_done, 0);
        send_rec(101, 0); idle();
        chk(batch_done, "R7 done after 2 of 2", batch_done, 1);
        @(negedge clk); #1;
        chk(batch_done, "R7 done holds", batch_done, 1);
        send_rec(102, 0); idle();
        chk(!batch_done, "R7 new batch", batch_done, 0);

        // R7 length 0
        cfg_write(2'd1, 32'h0);
        cfg_write(2'd0, 32'h1);
        send_rec(110, 0); idle();
        send_rec(111, 0); idle();
        chk(!batch_done, "R7 zero length never done", batch_done, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule